// File: doc/BRIEF.md
# Pipelined Argmax Selection Tree

This block takes a parameterized array of equal-width words and returns the word with the largest quality. Quality is the unsigned number held in the low `QUAL_W` bits of each word. The block also returns the position of that word in the array. When two or more words share the largest quality, the one at the lowest position wins. A typical use is picking the best candidate among several requesters, channels or search results in a single pass.

Selection runs through a binary reduction tree of compare-and-select nodes. The input array is padded up to the next power of two. Padding entries carry a "live" flag that is cleared, so they never beat a real input. The tree therefore has `ceil(log2(N_IN))` levels.

Registers are optional in three places, each set by a parameter: the input, the output, and every `LVL_EVERY`-th tree level. The last tree level is not counted, because the output register covers it. A valid flag travels beside the data through the same registers. It takes no part in the selection. Setting `QUAL_W` to 1 and putting a valid bit in the word LSB makes the block a pick-first-valid selector.

Top module: `argmax_tree`

## Requirements
- R1: `out_word` is the full word of the input whose bits `QUAL_W-1:0` form the largest unsigned value.
- R2: When several inputs share the largest quality, `out_idx` is the smallest of their indices, and `out_word` is the word at that index.
- R3: `out_idx` is `ceil(log2(N_IN))` bits wide and always below `N_IN`. Padding entries never win.
- R4: Bits of a word above `QUAL_W-1` have no effect on which input wins.
- R5: The latency in cycles from `in_words` to `out_word`/`out_idx` is the sum of three terms: `IN_REG`, `OUT_REG`, and the number of tree levels k with 1 <= k < levels and k mod `LVL_EVERY` = 0 (none when `LVL_EVERY` = 0). With the defaults (10 inputs, 4 levels, `LVL_EVERY`=2, both edge registers on), the latency is 3.
- R6: `out_valid` equals `in_valid` delayed by exactly the R5 latency. `in_valid` does not change the selection.
- R7: While `rst_n` is low at a clock edge, every pipeline register clears. As a result, `out_valid`, `out_word` and `out_idx` read 0 after that edge.
- R8: With no register enabled, the block is purely combinational, with latency 0.
- R9: With `QUAL_W`=1, the winner is the lowest index whose word has bit 0 set. If no word has bit 0 set, index 0 wins.
- R10: Input counts that are not a power of two work correctly. This includes a winner in the last position, which has no real partner at the first level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of pipeline registers |
| in_valid | input | 1 | Valid flag carried alongside the data |
| in_words | input | N_IN*WORD_W | Input words; word j sits at bits j*WORD_W upward |
| out_valid | output | 1 | Delayed copy of `in_valid` |
| out_word | output | WORD_W | Full word of the winner |
| out_idx | output | ceil(log2(N_IN)) | Index of the winner |

## Verification
The hardest case to reach from the ports is a tie that is settled deep in the tree. This happens when two equal-best words sit in different halves of the padded array, so they only meet at the root. A wrong tie rule at any lower level would still pass simple tests.

The vector table places equal maxima at indices 3 and 6, and at indices 0 and 9. It also places a unique maximum at index 9, whose first-level partner is the highest real input (8), with only padding entries beyond it. Vectors are streamed back to back, so every pipeline stage holds a different case at once.

A second, register-free instance with 5 inputs and a 1-bit quality covers the combinational and pick-first-valid variants.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

  // Smallest r with 2**r >= n.
  function automatic int log2_ceil(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  // Offset of level k inside the flattened heap of a tree with pad leaves.
  function automatic int level_base(input int pad, input int k);
    return 2 * pad - 2 * (pad >> k);
  endfunction

  // Level k (1..lvls) output is registered inside the tree.
  function automatic bit level_has_reg(input int every, input int lvls, input int k);
    return (every > 0) && (k < lvls) && ((k % every) == 0);
  endfunction

  // Total register count on the data path.
  function automatic int pipe_latency(input bit in_reg, input bit out_reg,
                                      input int every, input int lvls);
    int n;
    n = int'(in_reg) + int'(out_reg);
    for (int k = 1; k <= lvls; k++)
      if (level_has_reg(every, lvls, k)) n++;
    return n;
  endfunction

endpackage

// File: rtl/argmax_pipe_reg.sv
module argmax_pipe_reg #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_wire
      logic unused_pins;
      assign unused_pins = clk ^ rst_n;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/argmax_node.sv
// Entry layout: {live, idx[IDX_W-1:0], word[WORD_W-1:0]}
module argmax_node #(
  parameter int WORD_W = 12,
  parameter int QUAL_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic [WORD_W+IDX_W:0] lo,
  input  logic [WORD_W+IDX_W:0] hi,
  output logic [WORD_W+IDX_W:0] win
);
  logic              lo_live, hi_live;
  logic [QUAL_W-1:0] lo_q, hi_q;
  logic              hi_better;

  assign lo_live = lo[WORD_W+IDX_W];
  assign hi_live = hi[WORD_W+IDX_W];
  assign lo_q    = lo[QUAL_W-1:0];
  assign hi_q    = hi[QUAL_W-1:0];

  // Upper side only wins on strictly greater quality: lowest index keeps ties.
  assign hi_better = hi_live && (!lo_live || (hi_q > lo_q));
  assign win       = hi_better ? hi : lo;
endmodule

// File: rtl/argmax_tree.sv
module argmax_tree
  import argmax_pkg::*;
#(
  parameter int N_IN      = 10,
  parameter int WORD_W    = 12,
  parameter int QUAL_W    = 4,
  parameter bit IN_REG    = 1'b1,
  parameter bit OUT_REG   = 1'b1,
  parameter int LVL_EVERY = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [N_IN*WORD_W-1:0]      in_words,
  output logic                        out_valid,
  output logic [WORD_W-1:0]           out_word,
  output logic [log2_ceil(N_IN)-1:0]  out_idx
);
  localparam int LVLS  = log2_ceil(N_IN);
  localparam int IDX_W = LVLS;
  localparam int PAD   = 1 << LVLS;
  localparam int ENT_W = WORD_W + IDX_W + 1;
  localparam int NODES = 2 * PAD - 1;

  logic [ENT_W-1:0]        heap [NODES];
  logic                    lvl_vld [LVLS+1];
  logic [ENT_W-2:0]        root_sel;
  logic [ENT_W-2:0]        fin;
  logic                    root_live;

  // Leaves: real inputs tagged live with their index, padding left dead.
  generate
    for (genvar j = 0; j < PAD; j++) begin : g_leaf
      logic [ENT_W-1:0] raw;
      if (j < N_IN) begin : g_real
        assign raw = {1'b1, IDX_W'(j), in_words[j*WORD_W +: WORD_W]};
      end else begin : g_pad
        assign raw = '0;
      end
      argmax_pipe_reg #(.W(ENT_W), .EN(IN_REG)) u_in (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(heap[j])
      );
    end
  endgenerate

  argmax_pipe_reg #(.W(1), .EN(IN_REG)) u_vin (
    .clk(clk), .rst_n(rst_n), .d(in_valid), .q(lvl_vld[0])
  );

  // Reduction levels.
  generate
    for (genvar k = 1; k <= LVLS; k++) begin : g_lvl
      localparam int CNT = PAD >> k;
      localparam int BI  = level_base(PAD, k - 1);
      localparam int BO  = level_base(PAD, k);
      localparam bit RG  = level_has_reg(LVL_EVERY, LVLS, k);
      for (genvar n = 0; n < CNT; n++) begin : g_node
        logic [ENT_W-1:0] pick;
        argmax_node #(.WORD_W(WORD_W), .QUAL_W(QUAL_W), .IDX_W(IDX_W)) u_node (
          .lo(heap[BI + 2*n]), .hi(heap[BI + 2*n + 1]), .win(pick)
        );
        argmax_pipe_reg #(.W(ENT_W), .EN(RG)) u_reg (
          .clk(clk), .rst_n(rst_n), .d(pick), .q(heap[BO + n])
        );
      end
      argmax_pipe_reg #(.W(1), .EN(RG)) u_vreg (
        .clk(clk), .rst_n(rst_n), .d(lvl_vld[k-1]), .q(lvl_vld[k])
      );
    end
  endgenerate

  // Root: a dead root only appears while registers hold their reset value.
  assign root_live = heap[NODES-1][ENT_W-1];
  assign root_sel  = root_live ? heap[NODES-1][ENT_W-2:0] : '0;

  argmax_pipe_reg #(.W(ENT_W-1), .EN(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .d(root_sel), .q(fin)
  );
  argmax_pipe_reg #(.W(1), .EN(OUT_REG)) u_vout (
    .clk(clk), .rst_n(rst_n), .d(lvl_vld[LVLS]), .q(out_valid)
  );

  assign out_word = fin[WORD_W-1:0];
  assign out_idx  = fin[WORD_W +: IDX_W];
endmodule

// File: rtl/argmax_tree_chk.sv
module argmax_tree_chk
  import argmax_pkg::*;
#(
  parameter int N_IN      = 10,
  parameter int WORD_W    = 12,
  parameter int QUAL_W    = 4,
  parameter bit IN_REG    = 1'b1,
  parameter bit OUT_REG   = 1'b1,
  parameter int LVL_EVERY = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [N_IN*WORD_W-1:0]     in_words,
  input logic                       out_valid,
  input logic [WORD_W-1:0]          out_word,
  input logic [log2_ceil(N_IN)-1:0] out_idx
);
  localparam int LVLS = log2_ceil(N_IN);
  localparam int LAT  = pipe_latency(IN_REG, OUT_REG, LVL_EVERY, LVLS);

  logic [N_IN*WORD_W-1:0] dly_w [LAT+1];
  logic                   dly_v [LAT+1];

  assign dly_w[0] = in_words;
  assign dly_v[0] = in_valid;

  generate
    for (genvar k = 0; k < LAT; k++) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dly_w[k+1] <= '0;
          dly_v[k+1] <= 1'b0;
        end else begin
          dly_w[k+1] <= dly_w[k];
          dly_v[k+1] <= dly_v[k];
        end
      end
    end
  endgenerate

  function automatic bit none_better(input logic [N_IN*WORD_W-1:0] ws,
                                     input logic [WORD_W-1:0] w);
    for (int j = 0; j < N_IN; j++)
      if (ws[j*WORD_W +: QUAL_W] > w[QUAL_W-1:0]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit earlier_worse(input logic [N_IN*WORD_W-1:0] ws,
                                       input logic [WORD_W-1:0] w, input int idx);
    for (int j = 0; j < N_IN; j++)
      if (j < idx && ws[j*WORD_W +: QUAL_W] >= w[QUAL_W-1:0]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit word_matches(input logic [N_IN*WORD_W-1:0] ws,
                                      input logic [WORD_W-1:0] w, input int idx);
    if (idx >= N_IN) return 1'b0;
    return ws[idx*WORD_W +: WORD_W] == w;
  endfunction

  assert_word_from_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> word_matches(dly_w[LAT], out_word, int'(out_idx)));

  assert_best_quality_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> none_better(dly_w[LAT], out_word));

  assert_tie_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> earlier_worse(dly_w[LAT], out_word, int'(out_idx)));

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_idx) < N_IN));

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == dly_v[LAT]);

  generate
    if (LAT > 0) begin : g_rst
      assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0 && out_idx == '0));
    end
  endgenerate
endmodule

bind argmax_tree argmax_tree_chk #(
  .N_IN(N_IN), .WORD_W(WORD_W), .QUAL_W(QUAL_W),
  .IN_REG(IN_REG), .OUT_REG(OUT_REG), .LVL_EVERY(LVL_EVERY)
) u_chk (.*);

// File: tb/argmax_tree_test.sv
module argmax_tree_test;
  localparam int N   = 10;
  localparam int WW  = 12;
  localparam int LAT = 3;   // R5: input reg + level-2 reg + output reg
  localparam int NV  = 6;
  localparam int FN  = 5;   // flat instance: 5 inputs, 4-bit words, 1-bit quality

  // Quality nibble per vector, index 0 first; word j = {8'(j*17), quality}.
  localparam logic [3:0] VQ [NV][N] = '{
    '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hF, 4'h8, 4'h9},
    '{4'h5, 4'h5, 4'h5, 4'hA, 4'h5, 4'h5, 4'hA, 4'h5, 4'h5, 4'h5},
    '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
    '{4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h2, 4'hE},
    '{4'hF, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'hF},
    '{4'h2, 4'h2, 4'h2, 4'h2, 4'h2, 4'hC, 4'h2, 4'h2, 4'h2, 4'h3}
  };
  localparam int VIDX [NV]  = '{7, 3, 0, 9, 0, 5};
  localparam bit VVAL [NV]  = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam string VREQ [NV] = '{"R1", "R2", "R2", "R10", "R2", "R4"};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [N*WW-1:0] in_words = '0;
  logic            out_valid;
  logic [WW-1:0]   out_word;
  logic [3:0]      out_idx;

  logic            f_valid = 1'b0;
  logic [FN*4-1:0] f_words = '0;
  logic            f_out_valid;
  logic [3:0]      f_out_word;
  logic [2:0]      f_out_idx;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  argmax_tree #(.N_IN(N), .WORD_W(WW), .QUAL_W(4), .IN_REG(1'b1),
                .OUT_REG(1'b1), .LVL_EVERY(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_word(out_word), .out_idx(out_idx)
  );

  argmax_tree #(.N_IN(FN), .WORD_W(4), .QUAL_W(1), .IN_REG(1'b0),
                .OUT_REG(1'b0), .LVL_EVERY(0)) uut_flat (
    .clk(clk), .rst_n(rst_n), .in_valid(f_valid), .in_words(f_words),
    .out_valid(f_out_valid), .out_word(f_out_word), .out_idx(f_out_idx)
  );

  function automatic logic [N*WW-1:0] build(input int v);
    logic [N*WW-1:0] w;
    for (int j = 0; j < N; j++) w[j*WW +: WW] = {8'(j * 17), VQ[v][j]};
    return w;
  endfunction

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7", "reset out_valid", out_valid, 0);
    chk("R7", "reset out_word", out_word, 0);
    chk("R7", "reset out_idx", out_idx, 0);
    rst_n = 1'b1;

    // Streamed vector table (R1, R2, R4, R6, R10)
    for (int i = 0; i < NV + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        int v;
        logic [N*WW-1:0] w;
        v = i - LAT;
        w = build(v);
        chk(VREQ[v], $sformatf("vec%0d idx", v), out_idx, VIDX[v]);
        chk("R1", $sformatf("vec%0d word", v), out_word, w[VIDX[v]*WW +: WW]);
        chk("R6", $sformatf("vec%0d valid", v), out_valid, VVAL[v]);
      end
      if (i < NV) begin
        in_words = build(i);
        in_valid = VVAL[i];
      end else begin
        in_words = '0;
        in_valid = 1'b0;
      end
    end

    // R5: exact latency of a single pulse
    @(negedge clk);
    in_words = build(0);
    in_valid = 1'b1;
    @(negedge clk);
    in_words = '0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R5", "valid before latency", out_valid, 0);
    @(negedge clk);
    chk("R5", "valid at latency", out_valid, 1);
    chk("R5", "idx at latency", out_idx, 7);
    @(negedge clk);
    chk("R5", "valid after pulse", out_valid, 0);
    chk("R5", "idx after pulse", out_idx, 0);

    // R7: reset in mid-flight clears the pipe
    in_words = build(3);
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7", "mid reset valid", out_valid, 0);
    chk("R7", "mid reset idx", out_idx, 0);
    chk("R7", "mid reset word", out_word, 0);
    rst_n = 1'b1;

    // R8, R9, R10: combinational pick-first-valid, 5 inputs; word j = {3'(j+1), vld}
    f_words = {3'd5, 1'b1, 3'd4, 1'b1, 3'd3, 1'b0, 3'd2, 1'b0, 3'd1, 1'b0};
    f_valid = 1'b1;
    #1;
    chk("R9", "flat first valid idx", f_out_idx, 3);
    chk("R9", "flat first valid word", f_out_word, 4'h9);
    chk("R8", "flat valid passthrough", f_out_valid, 1);
    f_words = {3'd5, 1'b0, 3'd4, 1'b0, 3'd3, 1'b0, 3'd2, 1'b0, 3'd1, 1'b0};
    f_valid = 1'b0;
    #1;
    chk("R9", "flat none valid idx", f_out_idx, 0);
    chk("R9", "flat none valid word", f_out_word, 4'h2);
    chk("R8", "flat valid low", f_out_valid, 0);
    f_words = {3'd5, 1'b1, 3'd4, 1'b0, 3'd3, 1'b0, 3'd2, 1'b0, 3'd1, 1'b0};
    #1;
    chk("R10", "flat last unpaired idx", f_out_idx, 4);
    chk("R3", "flat idx in range", (f_out_idx < FN), 1);

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule